// File: doc/BRIEF.md
# Thread Context Fork Allocator

This block performs the hardware side of a thread-spawn operation in a multithreaded core with a configurable number of thread contexts. A requester presents a start address, a destination register index, a data word and its own identity: virtual-processor binding, privilege mode and address-space identifier. The block looks at the per-context binding, allocatable, halt and activated bits and claims the lowest-numbered free context that belongs to the requester's virtual processor.

On the clock edge that accepts the request, the block registers one commit record. For one cycle this record drives the chosen context number, the restart address, the general-register write (index and data) and the new status fields. The surrounding register files take these values and write them. If no context qualifies, the block instead pulses a thread fault and presents exception code 1 for the virtual-processor control register. A request that arrives while a commit is still on the outputs is held off by a valid/ready handshake.

Top module: `tc_fork_alloc`

## Requirements
- R1: Only contexts numbered 0 to `cfg_last_i` take part in the scan. A `cfg_last_i` value at or above NUM_CTX-1 admits every context.
- R2: When several contexts qualify, the one with the lowest index is chosen.
- R3: A context qualifies only if its binding field in `ctx_vpe_i` (bits [i*VPE_W +: VPE_W]) equals `req_vpe_i`, its `ctx_dyn_i` bit is 1, its `ctx_halt_i` bit is 0 and its `ctx_act_i` bit is 0.
- R4: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both 1. After a successful scan, `wr_en_o` is 1 for exactly the following cycle, with `wr_ctx_o` set to the chosen index and `restart_o` set to the supplied start address.
- R5: In the commit cycle, `gpr_idx_o` and `gpr_data_o` carry the request's destination index and data word.
- R6: In the commit cycle, the status outputs show run state 0 (running), delay-slot 0, DT 1 and activated 1.
- R7: In the commit cycle, `st_ksu_o` equals the requester's privilege mode and `st_asid_o` equals the requester's address-space identifier.
- R8: When no context qualifies, `fault_o` is 1 for exactly the following cycle with `exc_code_o` equal to 1, and `wr_en_o` stays 0. Outside a fault cycle, `exc_code_o` is 0.
- R9: In the cycle after an accept, `req_ready_o` is 0, so a request held valid in that cycle is not taken and produces no second commit.
- R10: While reset is active and just after it, `req_ready_o` is 1 and `wr_en_o`, `fault_o` and `exc_code_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_last_i | input | CFG_W | Highest context index taking part in the scan |
| ctx_vpe_i | input | NUM_CTX*VPE_W | Virtual-processor binding of each context |
| ctx_dyn_i | input | NUM_CTX | Per-context dynamically-allocatable bit |
| ctx_halt_i | input | NUM_CTX | Per-context halt bit |
| ctx_act_i | input | NUM_CTX | Per-context activated bit |
| req_valid_i | input | 1 | Fork request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_start_i | input | ADDR_W | Start address for the new thread |
| req_dst_i | input | RIDX_W | Destination general-register index |
| req_data_i | input | DATA_W | Value for the destination register |
| req_vpe_i | input | VPE_W | Requester's virtual-processor binding |
| req_ksu_i | input | 2 | Requester's privilege mode |
| req_asid_i | input | ASID_W | Requester's address-space identifier |
| wr_en_o | output | 1 | One-cycle commit strobe for a successful fork |
| wr_ctx_o | output | IDX_W | Chosen context index |
| restart_o | output | ADDR_W | Restart address to store |
| gpr_idx_o | output | RIDX_W | General-register index to write |
| gpr_data_o | output | DATA_W | General-register data to write |
| st_rnst_o | output | 2 | New run-state field |
| st_ds_o | output | 1 | New delay-slot bit |
| st_dt_o | output | 1 | New DT bit |
| st_act_o | output | 1 | New activated bit |
| st_ksu_o | output | 2 | New privilege-mode field |
| st_asid_o | output | ASID_W | New address-space identifier |
| fault_o | output | 1 | One-cycle thread fault strobe |
| exc_code_o | output | 3 | Exception code, valid during fault_o |

## Verification
A wrong eligibility term or a wrong priority order shows up one cycle after the accept. Either the wrong `wr_ctx_o` appears, or a fault appears where a write was due, or the reverse. A stuck busy flag shows up at the ports at once, as `req_ready_o` staying low. Busy state that clears too early shows up as a second commit strobe one cycle after the first. A field that is latched from the wrong source shows up in the single commit cycle and is gone on the next cycle, so every check samples exactly that cycle.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

    localparam int KSU_W  = 2;
    localparam int RNST_W = 2;
    localparam int EXC_W  = 3;

    localparam logic [RNST_W-1:0] RNST_RUNNING    = 2'd0;
    localparam logic [EXC_W-1:0]  EXC_NONE        = 3'd0;
    localparam logic [EXC_W-1:0]  EXC_NO_FREE_CTX = 3'd1;

    typedef struct packed {
        logic [RNST_W-1:0] rnst;
        logic              ds;
        logic              dt;
        logic              act;
        logic [KSU_W-1:0]  ksu;
    } tcf_status_t;

    function automatic tcf_status_t fresh_status(input logic [KSU_W-1:0] ksu);
        tcf_status_t s;
        s.rnst = RNST_RUNNING;
        s.ds   = 1'b0;
        s.dt   = 1'b1;
        s.act  = 1'b1;
        s.ksu  = ksu;
        return s;
    endfunction

endpackage

// File: rtl/tcf_eligible.sv
module tcf_eligible #(
    parameter int NUM_CTX = 8,
    parameter int VPE_W   = 4,
    parameter int CFG_W   = 4
) (
    input  logic [CFG_W-1:0]         cfg_last_i,
    input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe_i,
    input  logic [NUM_CTX-1:0]       ctx_dyn_i,
    input  logic [NUM_CTX-1:0]       ctx_halt_i,
    input  logic [NUM_CTX-1:0]       ctx_act_i,
    input  logic [VPE_W-1:0]         req_vpe_i,
    output logic [NUM_CTX-1:0]       elig_o
);
    localparam int CMP_W = CFG_W + 1;

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        logic in_range;
        logic same_vpe;
        assign in_range = ({1'b0, cfg_last_i} >= CMP_W'(i));
        assign same_vpe = (ctx_vpe_i[i*VPE_W +: VPE_W] == req_vpe_i);
        assign elig_o[i] = in_range && same_vpe && ctx_dyn_i[i]
                           && !ctx_halt_i[i] && !ctx_act_i[i];
    end
endmodule

// File: rtl/tcf_prio_enc.sv
module tcf_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tcf_commit.sv
module tcf_commit
    import tcf_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 32,
    parameter int RIDX_W = 5,
    parameter int DATA_W = 32,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              found_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [RIDX_W-1:0] dst_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [KSU_W-1:0]  ksu_i,
    input  logic [ASID_W-1:0] asid_i,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  ctx_o,
    output logic [ADDR_W-1:0] restart_o,
    output logic [RIDX_W-1:0] gpr_idx_o,
    output logic [DATA_W-1:0] gpr_data_o,
    output tcf_status_t       status_o,
    output logic [ASID_W-1:0] asid_o,
    output logic              fault_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o     <= 1'b0;
            wr_en_o    <= 1'b0;
            fault_o    <= 1'b0;
            ctx_o      <= '0;
            restart_o  <= '0;
            gpr_idx_o  <= '0;
            gpr_data_o <= '0;
            status_o   <= '0;
            asid_o     <= '0;
        end else begin
            busy_o  <= accept_i;
            wr_en_o <= accept_i && found_i;
            fault_o <= accept_i && !found_i;
            if (accept_i && found_i) begin
                ctx_o      <= idx_i;
                restart_o  <= start_i;
                gpr_idx_o  <= dst_i;
                gpr_data_o <= data_i;
                status_o   <= fresh_status(ksu_i);
                asid_o     <= asid_i;
            end
        end
    end
endmodule

// File: rtl/tc_fork_alloc.sv
module tc_fork_alloc
    import tcf_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int VPE_W   = 4,
    parameter int CFG_W   = 4,
    parameter int ADDR_W  = 32,
    parameter int RIDX_W  = 5,
    parameter int DATA_W  = 32,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CFG_W-1:0]         cfg_last_i,
    input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe_i,
    input  logic [NUM_CTX-1:0]       ctx_dyn_i,
    input  logic [NUM_CTX-1:0]       ctx_halt_i,
    input  logic [NUM_CTX-1:0]       ctx_act_i,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic [ADDR_W-1:0]        req_start_i,
    input  logic [RIDX_W-1:0]        req_dst_i,
    input  logic [DATA_W-1:0]        req_data_i,
    input  logic [VPE_W-1:0]         req_vpe_i,
    input  logic [1:0]               req_ksu_i,
    input  logic [ASID_W-1:0]        req_asid_i,
    output logic                     wr_en_o,
    output logic [IDX_W-1:0]         wr_ctx_o,
    output logic [ADDR_W-1:0]        restart_o,
    output logic [RIDX_W-1:0]        gpr_idx_o,
    output logic [DATA_W-1:0]        gpr_data_o,
    output logic [1:0]               st_rnst_o,
    output logic                     st_ds_o,
    output logic                     st_dt_o,
    output logic                     st_act_o,
    output logic [1:0]               st_ksu_o,
    output logic [ASID_W-1:0]        st_asid_o,
    output logic                     fault_o,
    output logic [2:0]               exc_code_o
);
    logic [NUM_CTX-1:0] elig;
    logic               found;
    logic [IDX_W-1:0]   pick;
    logic               busy;
    logic               accept;
    tcf_status_t        status;

    tcf_eligible #(
        .NUM_CTX (NUM_CTX),
        .VPE_W   (VPE_W),
        .CFG_W   (CFG_W)
    ) u_elig (
        .cfg_last_i (cfg_last_i),
        .ctx_vpe_i  (ctx_vpe_i),
        .ctx_dyn_i  (ctx_dyn_i),
        .ctx_halt_i (ctx_halt_i),
        .ctx_act_i  (ctx_act_i),
        .req_vpe_i  (req_vpe_i),
        .elig_o     (elig)
    );

    tcf_prio_enc #(
        .N     (NUM_CTX),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i   (elig),
        .found_o (found),
        .idx_o   (pick)
    );

    assign req_ready_o = !busy;
    assign accept      = req_valid_i && !busy;

    tcf_commit #(
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W),
        .RIDX_W (RIDX_W),
        .DATA_W (DATA_W),
        .ASID_W (ASID_W)
    ) u_commit (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .found_i    (found),
        .idx_i      (pick),
        .start_i    (req_start_i),
        .dst_i      (req_dst_i),
        .data_i     (req_data_i),
        .ksu_i      (req_ksu_i),
        .asid_i     (req_asid_i),
        .busy_o     (busy),
        .wr_en_o    (wr_en_o),
        .ctx_o      (wr_ctx_o),
        .restart_o  (restart_o),
        .gpr_idx_o  (gpr_idx_o),
        .gpr_data_o (gpr_data_o),
        .status_o   (status),
        .asid_o     (st_asid_o),
        .fault_o    (fault_o)
    );

    assign st_rnst_o  = status.rnst;
    assign st_ds_o    = status.ds;
    assign st_dt_o    = status.dt;
    assign st_act_o   = status.act;
    assign st_ksu_o   = status.ksu;
    assign exc_code_o = fault_o ? EXC_NO_FREE_CTX : EXC_NONE;
endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
    parameter int NUM_CTX = 8,
    parameter int VPE_W   = 4,
    parameter int CFG_W   = 4,
    parameter int ADDR_W  = 32,
    parameter int ASID_W  = 8,
    parameter int IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic [CFG_W-1:0]         cfg_last_i,
    input logic [NUM_CTX-1:0]       ctx_dyn_i,
    input logic [NUM_CTX-1:0]       ctx_halt_i,
    input logic [NUM_CTX-1:0]       ctx_act_i,
    input logic                     req_valid_i,
    input logic                     req_ready_o,
    input logic [ADDR_W-1:0]        req_start_i,
    input logic [1:0]               req_ksu_i,
    input logic [ASID_W-1:0]        req_asid_i,
    input logic                     wr_en_o,
    input logic [IDX_W-1:0]         wr_ctx_o,
    input logic [ADDR_W-1:0]        restart_o,
    input logic [1:0]               st_rnst_o,
    input logic                     st_ds_o,
    input logic                     st_dt_o,
    input logic                     st_act_o,
    input logic [1:0]               st_ksu_o,
    input logic [ASID_W-1:0]        st_asid_o,
    input logic                     fault_o,
    input logic [2:0]               exc_code_o
);
    logic                 took;
    logic [CFG_W-1:0]     s_cfg;
    logic [NUM_CTX-1:0]   s_dyn, s_halt, s_act;
    logic [ADDR_W-1:0]    s_start;
    logic [1:0]           s_ksu;
    logic [ASID_W-1:0]    s_asid;

    assign took = req_valid_i && req_ready_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_cfg <= '0; s_dyn <= '0; s_halt <= '0; s_act <= '0;
            s_start <= '0; s_ksu <= '0; s_asid <= '0;
        end else if (took) begin
            s_cfg <= cfg_last_i; s_dyn <= ctx_dyn_i; s_halt <= ctx_halt_i;
            s_act <= ctx_act_i; s_start <= req_start_i;
            s_ksu <= req_ksu_i; s_asid <= req_asid_i;
        end
    end

    p_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> ({1'b0, s_cfg} >= (CFG_W+1)'(wr_ctx_o)));
    p_chosen_free_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (s_dyn[wr_ctx_o] && !s_halt[wr_ctx_o] && !s_act[wr_ctx_o]));
    p_commit_next_r4: assert property (@(posedge clk) disable iff (rst)
        took |=> (wr_en_o || fault_o));
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (restart_o == s_start));
    p_status_bits_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (st_rnst_o == 2'd0 && !st_ds_o && st_dt_o && st_act_o));
    p_inherit_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (st_ksu_o == s_ksu && st_asid_o == s_asid));
    p_fault_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_o && fault_o));
    p_fault_code_r8: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (exc_code_o == 3'd1));
    p_hold_off_r9: assert property (@(posedge clk) disable iff (rst)
        took |=> !req_ready_o);
endmodule

bind tc_fork_alloc tcf_checker #(
    .NUM_CTX (NUM_CTX),
    .VPE_W   (VPE_W),
    .CFG_W   (CFG_W),
    .ADDR_W  (ADDR_W),
    .ASID_W  (ASID_W),
    .IDX_W   (IDX_W)
) u_tcf_checker (
    .clk         (clk),
    .rst         (rst),
    .cfg_last_i  (cfg_last_i),
    .ctx_dyn_i   (ctx_dyn_i),
    .ctx_halt_i  (ctx_halt_i),
    .ctx_act_i   (ctx_act_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_start_i (req_start_i),
    .req_ksu_i   (req_ksu_i),
    .req_asid_i  (req_asid_i),
    .wr_en_o     (wr_en_o),
    .wr_ctx_o    (wr_ctx_o),
    .restart_o   (restart_o),
    .st_rnst_o   (st_rnst_o),
    .st_ds_o     (st_ds_o),
    .st_dt_o     (st_dt_o),
    .st_act_o    (st_act_o),
    .st_ksu_o    (st_ksu_o),
    .st_asid_o   (st_asid_o),
    .fault_o     (fault_o),
    .exc_code_o  (exc_code_o)
);

// File: tb/test_tc_fork_alloc.sv
module test_tc_fork_alloc;
    localparam int N = 8;
    localparam int VW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      cfg_last = 4'd7;
    logic [N*VW-1:0] ctx_vpe = '0;
    logic [N-1:0]    ctx_dyn = '0, ctx_halt = '0, ctx_act = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [31:0]     req_start = '0;
    logic [4:0]      req_dst = '0;
    logic [31:0]     req_data = '0;
    logic [3:0]      req_vpe = '0;
    logic [1:0]      req_ksu = '0;
    logic [7:0]      req_asid = '0;
    logic            wr_en;
    logic [2:0]      wr_ctx;
    logic [31:0]     restart;
    logic [4:0]      gpr_idx;
    logic [31:0]     gpr_data;
    logic [1:0]      st_rnst;
    logic            st_ds, st_dt, st_act;
    logic [1:0]      st_ksu;
    logic [7:0]      st_asid;
    logic            fault;
    logic [2:0]      exc_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    tc_fork_alloc i_tc_fork_alloc (
        .clk(clk), .rst(rst), .cfg_last_i(cfg_last), .ctx_vpe_i(ctx_vpe),
        .ctx_dyn_i(ctx_dyn), .ctx_halt_i(ctx_halt), .ctx_act_i(ctx_act),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_start_i(req_start), .req_dst_i(req_dst), .req_data_i(req_data),
        .req_vpe_i(req_vpe), .req_ksu_i(req_ksu), .req_asid_i(req_asid),
        .wr_en_o(wr_en), .wr_ctx_o(wr_ctx), .restart_o(restart),
        .gpr_idx_o(gpr_idx), .gpr_data_o(gpr_data), .st_rnst_o(st_rnst),
        .st_ds_o(st_ds), .st_dt_o(st_dt), .st_act_o(st_act), .st_ksu_o(st_ksu),
        .st_asid_o(st_asid), .fault_o(fault), .exc_code_o(exc_code)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every context bound to vpe v, allocatable, running, not active
    task automatic all_free(input logic [3:0] v);
        for (int i = 0; i < N; i++) ctx_vpe[i*VW +: VW] = v;
        ctx_dyn = '1; ctx_halt = '0; ctx_act = '0;
    endtask

    // drive one request at a negedge; return at the negedge after the accept edge
    task automatic fork_once(input logic [31:0] s, input logic [4:0] d,
                             input logic [31:0] v, input logic [3:0] vpe,
                             input logic [1:0] k, input logic [7:0] a);
        @(negedge clk);
        req_start = s; req_dst = d; req_data = v; req_vpe = vpe;
        req_ksu = k; req_asid = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 ready", 64'(req_ready), 64'd1);
        chk("R10 wr_en", 64'(wr_en), 64'd0);
        chk("R10 fault", 64'(fault), 64'd0);
        chk("R10 exc", 64'(exc_code), 64'd0);
    endtask

    task automatic t_basic;
        cfg_last = 4'd7; all_free(4'd3);
        fork_once(32'h0000_4000, 5'd9, 32'hCAFE_0001, 4'd3, 2'd2, 8'h5A);
        chk("R4 wr_en", 64'(wr_en), 64'd1);
        chk("R2 ctx", 64'(wr_ctx), 64'd0);
        chk("R4 restart", 64'(restart), 64'h4000);
        chk("R5 gpr idx", 64'(gpr_idx), 64'd9);
        chk("R5 gpr data", 64'(gpr_data), 64'hCAFE_0001);
        chk("R6 status", 64'({st_rnst, st_ds, st_dt, st_act}), 64'b00_0_1_1);
        chk("R7 ksu", 64'(st_ksu), 64'd2);
        chk("R7 asid", 64'(st_asid), 64'h5A);
        chk("R8 no fault", 64'(fault), 64'd0);
        chk("R9 not ready", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk("R4 single pulse", 64'(wr_en), 64'd0);
        chk("R9 ready again", 64'(req_ready), 64'd1);
    endtask

    task automatic t_filters;
        all_free(4'd1);
        ctx_vpe[0*VW +: VW] = 4'd2;  // wrong binding
        ctx_halt[1] = 1'b1;          // halted
        ctx_act[2]  = 1'b1;          // already active
        ctx_dyn[3]  = 1'b0;          // not allocatable
        fork_once(32'h100, 5'd1, 32'h11, 4'd1, 2'd0, 8'h01);
        chk("R3 skip ineligible", 64'(wr_ctx), 64'd4);
        chk("R3 wr_en", 64'(wr_en), 64'd1);
    endtask

    task automatic t_lowest;
        all_free(4'd5);
        ctx_dyn = 8'b0110_0000;
        fork_once(32'h200, 5'd2, 32'h22, 4'd5, 2'd1, 8'h77);
        chk("R2 lowest of 5,6", 64'(wr_ctx), 64'd5);
        chk("R7 ksu second", 64'(st_ksu), 64'd1);
        chk("R7 asid second", 64'(st_asid), 64'h77);
    endtask

    task automatic t_limit;
        all_free(4'd0);
        ctx_dyn = 8'b0100_0000;
        cfg_last = 4'd5;
        fork_once(32'h300, 5'd3, 32'h33, 4'd0, 2'd0, 8'h00);
        chk("R1 ctx6 beyond limit", 64'(fault), 64'd1);
        chk("R1 no write", 64'(wr_en), 64'd0);
        cfg_last = 4'd6;
        fork_once(32'h304, 5'd3, 32'h34, 4'd0, 2'd0, 8'h00);
        chk("R1 ctx6 at limit", 64'(wr_ctx), 64'd6);
        chk("R1 wr_en", 64'(wr_en), 64'd1);
        ctx_dyn = 8'b1000_0000;
        cfg_last = 4'd15;
        fork_once(32'h308, 5'd3, 32'h35, 4'd0, 2'd0, 8'h00);
        chk("R1 clamp all", 64'(wr_ctx), 64'd7);
        cfg_last = 4'd7;
    endtask

    task automatic t_nofree;
        all_free(4'd2);
        fork_once(32'h400, 5'd4, 32'h44, 4'd9, 2'd0, 8'h00);
        chk("R8 fault", 64'(fault), 64'd1);
        chk("R8 exc code", 64'(exc_code), 64'd1);
        chk("R8 no write", 64'(wr_en), 64'd0);
        @(negedge clk);
        chk("R8 fault pulse", 64'(fault), 64'd0);
        chk("R8 exc cleared", 64'(exc_code), 64'd0);
    endtask

    task automatic t_busy;
        all_free(4'd6);
        @(negedge clk);
        req_start = 32'h500; req_dst = 5'd5; req_data = 32'h55;
        req_vpe = 4'd6; req_ksu = 2'd3; req_asid = 8'h33; req_valid = 1'b1;
        @(negedge clk);
        chk("R9 first commit", 64'(wr_en), 64'd1);
        chk("R9 held off", 64'(req_ready), 64'd0);
        req_data = 32'h66;           // valid stays high through busy cycle
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 no second commit", 64'(wr_en), 64'd0);
        chk("R9 no fault", 64'(fault), 64'd0);
        chk("R9 data kept", 64'(gpr_data), 64'h55);
        @(negedge clk);
        chk("R9 idle", 64'(wr_en), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_filters();
        t_lowest();
        t_limit();
        t_nofree();
        t_busy();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule